// File: doc/BRIEF.md
# Multi-Port Cell Receive Bus Controller

This block sits on the physical-layer side of a shared cell bus and hands received cells to an ATM-layer device. Every port owns a small cell store that line-side logic fills one 32-bit word at a time. Thirteen words make one complete cell. The ATM-layer device polls ports through an address bus to learn which ones hold cells. It then selects one port by pulling an active-low enable, and reads that port's oldest cell as a run of 32-bit words. Each word carries a parity bit, and the first word of every cell carries a start marker.

Each port also drives its own availability flag, and this flag has hysteresis. It rises once the port holds more complete cells than a programmable threshold. It drops only when the port has no complete cell left.

Two bus personalities are supported. In the shared-bus mode, the data bus and the polled flag report output enables only while they are actually in use, and only the low five address bits count. In the point-to-point mode, both outputs are always driven and the full eight-bit address counts. A configuration bit controls the cell's second stored word, which carries the header check byte and three pad bytes: it is either sent or skipped.

Top module: `cellrx_bus_ctrl`

## Requirements
- R1: A port is selected on a rising clock edge where `rx_en_n` is sampled low, was sampled high on the previous edge, and `rx_addr` names a valid port that holds at least one complete cell. The cell's first word appears on the outputs at that same edge. While the cell is in progress, changes to `rx_addr` and new enable falls are ignored. Selecting an empty port transfers nothing.
- R2: `rx_soc` is high only together with the first word of a cell.
- R3: `rx_prty` makes the 33 bits {`rx_data`, `rx_prty`} hold an odd number of ones when `cfg_even_par`=0, and an even number when `cfg_even_par`=1. This holds on every cycle after the first clock out of reset.
- R4: Each bit of `rx_dxa` is set when its port holds more complete cells than `cfg_thresh`, and cleared when the port holds none. Otherwise it keeps its value. It follows the cell count one clock later.
- R5: `rx_pxa` is registered on each edge from the `rx_dxa` bit of the port named by `rx_addr`. It is 0 for the null address and for addresses above the last port.
- R6: With `cfg_l3`=0, only `rx_addr[4:0]` is decoded and 5'h1F is the null address. `rx_data_oe` is high exactly on cycles that carry a cell word. `rx_pxa_oe` is high on the cycle after a non-null address is sampled.
- R7: With `cfg_l3`=1, all 8 address bits are decoded and 8'hFF is the null address. From the first clock onward, `rx_data_oe` and `rx_pxa_oe` are both high.
- R8: With `cfg_hec`=1, a cell is sent as stored words 0 to 12 in order, 13 transfers. With `cfg_hec`=0, stored word 1 is skipped, giving 12 transfers.
- R9: Sampling `rx_en_n` high during a cell pauses it. On those cycles `rx_data` and `rx_soc` are 0. The cell resumes at the next word without losing any.
- R10: After the last word the port is released. Holding `rx_en_n` low afterwards transfers nothing until the enable rises and falls again.
- R11: After a clock with `rst_n` low, every output is 0 and all ports are empty.
- R12: `ln_we` writes `ln_data` to port `ln_port`. Every 13 accepted words to a port complete one cell. A cell's first word is dropped when that port already holds `CELLS` complete cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_l3 | input | 1 | 1 = point-to-point mode, 0 = shared-bus mode |
| cfg_hec | input | 1 | 1 = send the header-check word |
| cfg_even_par | input | 1 | 1 = even parity, 0 = odd |
| cfg_thresh | input | CNT_W | Cell-count threshold for the availability flags |
| ln_we | input | 1 | Line-side word write strobe |
| ln_port | input | PW | Line-side destination port |
| ln_data | input | 32 | Line-side cell word |
| rx_addr | input | ADDR_W | Poll / select address |
| rx_en_n | input | 1 | Active-low read enable |
| rx_data | output | 32 | Cell word |
| rx_prty | output | 1 | Parity over rx_data |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_data_oe | output | 1 | Data bus drive enable |
| rx_dxa | output | NPORTS | Per-port direct cell-available flags |
| rx_pxa | output | 1 | Polled cell-available flag |
| rx_pxa_oe | output | 1 | Polled flag drive enable |

## Verification
Three things are hard to reach from the ports. The first is a flag that must stay high while its port drains from above the threshold down to a single cell. The second is an in-progress cell that must ignore both a new address and a fresh enable fall. The third is a port whose store is already full when more line words arrive. The stimulus fills one port past the threshold and drains it one cell at a time, polling between reads. During one read it raises the enable for two cycles and retargets the address, then holds the enable low past the last word. A final phase pushes five cells into a four-cell port and counts the start markers as the port is emptied. A behavioural queue model checks every output on every clock.

// File: rtl/cellrx_pkg.sv
// Shared constants and helpers for the cell receive bus controller.
// Assumes 32-bit words and a fixed 13-word stored cell layout.
package cellrx_pkg;
    localparam int WORD_W     = 32;
    localparam int CELL_WORDS = 13;
    localparam int HEC_IDX    = 1;
    localparam int IDX_W      = $clog2(CELL_WORDS);
    localparam int L2_ADDR_W  = 5;

    // Parity bit for one word: even=1 gives even total ones, else odd.
    function automatic logic par_bit(input logic [WORD_W-1:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction
endpackage

// File: rtl/cellrx_port_fifo.sv
// Per-port cell store: a word memory organised as CELLS slots of 13 words,
// with a count of complete cells and a hysteresis availability flag.
// Assumes the reader pops only when at least one complete cell is held,
// and reads words of the head cell in any order by index.
module cellrx_port_fifo
    import cellrx_pkg::*;
#(
    parameter int CELLS = 4,
    localparam int CNT_W  = $clog2(CELLS + 1),
    localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int DEPTH  = CELLS * CELL_WORDS,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pop,
    input  logic [CNT_W-1:0]  thresh,
    output logic              cell_avail,
    output logic              dxa
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  cnt;
    logic              accept, commit;
    logic [AW-1:0]     wr_addr, rd_addr;

    assign accept     = wr_en && !(wr_idx == '0 && cnt == CNT_W'(CELLS));
    assign commit     = accept && (wr_idx == IDX_W'(CELL_WORDS - 1));
    assign wr_addr    = AW'(int'(wr_slot) * CELL_WORDS + int'(wr_idx));
    assign rd_addr    = AW'(int'(rd_slot) * CELL_WORDS + int'(rd_idx));
    assign rd_data    = mem[rd_addr];
    assign cell_avail = (cnt != '0);

    // Word storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_addr] <= wr_data;
    end

    // Write cursor, read slot and complete-cell count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
            rd_slot <= '0;
            wr_idx  <= '0;
            cnt     <= '0;
        end else begin
            if (accept) begin
                if (commit) begin
                    wr_idx  <= '0;
                    wr_slot <= (wr_slot == SLOT_W'(CELLS - 1)) ? '0 : wr_slot + 1'b1;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
            if (pop) rd_slot <= (rd_slot == SLOT_W'(CELLS - 1)) ? '0 : rd_slot + 1'b1;
            cnt <= cnt + CNT_W'(commit) - CNT_W'(pop);
        end
    end

    // Availability flag: set above threshold, clear only when empty.
    always_ff @(posedge clk) begin
        if (!rst_n)               dxa <= 1'b0;
        else if (cnt > thresh)    dxa <= 1'b1;
        else if (cnt == '0)       dxa <= 1'b0;
    end

    a_r4_fall_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dxa) |-> ($past(cnt) == '0));
    a_r4_rise_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dxa) |-> ($past(cnt) > $past(thresh)));
    a_r12_pop_has_cell: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(CELLS));
endmodule

// File: rtl/cellrx_sel_ctrl.sv
// Selection and transfer sequencer: latches a port on an enable fall,
// walks the head cell word by word while the enable is low, and
// registers data, parity, start marker and data drive enable.
// Assumes rd_data is the selected port's word at index rd_idx.
module cellrx_sel_ctrl
    import cellrx_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [PW-1:0]     addr_port,
    input  logic              addr_valid,
    input  logic [NPORTS-1:0] cell_avail,
    input  logic              cfg_hec,
    input  logic              cfg_even_par,
    input  logic              cfg_l3,
    input  logic [WORD_W-1:0] rd_data,
    output logic [PW-1:0]     cur_port,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [NPORTS-1:0] pop,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_prty,
    output logic              rx_soc,
    output logic              rx_data_oe
);
    logic              en_n_q, active;
    logic [PW-1:0]     port_q;
    logic [IDX_W-1:0]  idx_q, idx_next;
    logic              start, xfer, last;
    logic [WORD_W-1:0] out_word;

    assign start    = !active && en_n_q && !en_n && addr_valid && cell_avail[addr_port];
    assign xfer     = !en_n && (active || start);
    assign cur_port = active ? port_q : addr_port;
    assign rd_idx   = active ? idx_q : '0;
    assign last     = (rd_idx == IDX_W'(CELL_WORDS - 1));
    assign idx_next = (rd_idx == '0 && !cfg_hec) ? IDX_W'(HEC_IDX + 1) : rd_idx + 1'b1;
    assign out_word = xfer ? rd_data : '0;

    // Release the head cell of the current port after its last word.
    always_comb begin
        pop = '0;
        if (xfer && last) pop[cur_port] = 1'b1;
    end

    // Transfer state and registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_n_q     <= 1'b1;
            active     <= 1'b0;
            port_q     <= '0;
            idx_q      <= '0;
            rx_data    <= '0;
            rx_prty    <= 1'b0;
            rx_soc     <= 1'b0;
            rx_data_oe <= 1'b0;
        end else begin
            en_n_q <= en_n;
            if (xfer) begin
                active <= !last;
                port_q <= cur_port;
                idx_q  <= last ? '0 : idx_next;
            end
            rx_data    <= out_word;
            rx_prty    <= par_bit(out_word, cfg_even_par);
            rx_soc     <= xfer && (rd_idx == '0);
            rx_data_oe <= cfg_l3 || xfer;
        end
    end

    a_r2_soc_starts_cell: assert property (@(posedge clk) disable iff (!rst_n)
        rx_soc |-> !$past(active));
    a_r6_l2_oe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_oe && !$past(cfg_l3)) |-> !$past(en_n));
    a_r7_l3_data_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_l3) && $past(rst_n)) |-> rx_data_oe);
    a_r9_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && $past(en_n)) |-> (active && $stable(idx_q)));
endmodule

// File: rtl/cellrx_poll.sv
// Polled availability: registers the flag of the addressed port and
// the polled-flag drive enable for the selected bus mode.
// Assumes address decoding (valid port, null code) is done upstream.
module cellrx_poll #(
    parameter int NPORTS = 4,
    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     addr_port,
    input  logic              addr_valid,
    input  logic              is_null,
    input  logic [NPORTS-1:0] dxa,
    input  logic              cfg_l3,
    output logic              rx_pxa,
    output logic              rx_pxa_oe
);
    // Sample the addressed port's flag and the drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pxa    <= 1'b0;
            rx_pxa_oe <= 1'b0;
        end else begin
            rx_pxa    <= addr_valid && dxa[addr_port];
            rx_pxa_oe <= cfg_l3 || !is_null;
        end
    end

    a_r5_null_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_null) |-> !rx_pxa);
    a_r6_l2_null_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_l3) && $past(is_null)) |-> !rx_pxa_oe);
    a_r7_l3_poll_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_l3) && $past(rst_n)) |-> rx_pxa_oe);
endmodule

// File: rtl/cellrx_bus_ctrl.sv
// Top of the multi-port cell receive bus controller: decodes the address
// for the active bus mode, holds one cell store per port, and joins the
// transfer sequencer and the polled-flag logic.
// Assumes all inputs are synchronous to clk.
module cellrx_bus_ctrl
    import cellrx_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int CELLS  = 4,
    parameter int ADDR_W = 8,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int CNT_W = $clog2(CELLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_l3,
    input  logic              cfg_hec,
    input  logic              cfg_even_par,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic              ln_we,
    input  logic [PW-1:0]     ln_port,
    input  logic [WORD_W-1:0] ln_data,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              rx_en_n,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_prty,
    output logic              rx_soc,
    output logic              rx_data_oe,
    output logic [NPORTS-1:0] rx_dxa,
    output logic              rx_pxa,
    output logic              rx_pxa_oe
);
    logic [ADDR_W-1:0] eff_addr, null_code;
    logic              is_null, addr_valid;
    logic [PW-1:0]     addr_port, cur_port;
    logic [IDX_W-1:0]  rd_idx;
    logic [NPORTS-1:0] pop, cell_avail;
    logic [WORD_W-1:0] rd_bus [NPORTS];
    logic [WORD_W-1:0] rd_word;

    // Mode-dependent address decode.
    assign eff_addr   = cfg_l3 ? rx_addr
                               : {{(ADDR_W-L2_ADDR_W){1'b0}}, rx_addr[L2_ADDR_W-1:0]};
    assign null_code  = cfg_l3 ? {ADDR_W{1'b1}} : ADDR_W'((1 << L2_ADDR_W) - 1);
    assign is_null    = (eff_addr == null_code);
    assign addr_valid = !is_null && (eff_addr < ADDR_W'(NPORTS));
    assign addr_port  = eff_addr[PW-1:0];
    assign rd_word    = rd_bus[cur_port];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        cellrx_port_fifo #(.CELLS(CELLS)) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (ln_we && (ln_port == PW'(p))),
            .wr_data    (ln_data),
            .rd_idx     (rd_idx),
            .rd_data    (rd_bus[p]),
            .pop        (pop[p]),
            .thresh     (cfg_thresh),
            .cell_avail (cell_avail[p]),
            .dxa        (rx_dxa[p])
        );
    end

    cellrx_sel_ctrl #(.NPORTS(NPORTS)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_n         (rx_en_n),
        .addr_port    (addr_port),
        .addr_valid   (addr_valid),
        .cell_avail   (cell_avail),
        .cfg_hec      (cfg_hec),
        .cfg_even_par (cfg_even_par),
        .cfg_l3       (cfg_l3),
        .rd_data      (rd_word),
        .cur_port     (cur_port),
        .rd_idx       (rd_idx),
        .pop          (pop),
        .rx_data      (rx_data),
        .rx_prty      (rx_prty),
        .rx_soc       (rx_soc),
        .rx_data_oe   (rx_data_oe)
    );

    cellrx_poll #(.NPORTS(NPORTS)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_port  (addr_port),
        .addr_valid (addr_valid),
        .is_null    (is_null),
        .dxa        (rx_dxa),
        .cfg_l3     (cfg_l3),
        .rx_pxa     (rx_pxa),
        .rx_pxa_oe  (rx_pxa_oe)
    );

    a_r1_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
endmodule

// File: tb/cellrx_bus_ctrl_test.sv
`timescale 1ns/1ps
module cellrx_bus_ctrl_test;
    localparam int NP = 4;
    localparam int CELLS = 4;
    localparam int CW = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_l3 = 1'b0, cfg_hec = 1'b1, cfg_even_par = 1'b0;
    logic [2:0]  cfg_thresh = 3'd1;
    logic        ln_we = 1'b0;
    logic [1:0]  ln_port = '0;
    logic [31:0] ln_data = '0;
    logic [7:0]  rx_addr = 8'hFF;
    logic        rx_en_n = 1'b1;
    logic [31:0] rx_data;
    logic        rx_prty, rx_soc, rx_data_oe, rx_pxa, rx_pxa_oe;
    logic [NP-1:0] rx_dxa;

    int tests = 0, fails = 0;
    bit chk_on = 1'b0;

    always #2 clk = ~clk;

    cellrx_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_l3(cfg_l3), .cfg_hec(cfg_hec),
        .cfg_even_par(cfg_even_par), .cfg_thresh(cfg_thresh),
        .ln_we(ln_we), .ln_port(ln_port), .ln_data(ln_data),
        .rx_addr(rx_addr), .rx_en_n(rx_en_n), .rx_data(rx_data),
        .rx_prty(rx_prty), .rx_soc(rx_soc), .rx_data_oe(rx_data_oe),
        .rx_dxa(rx_dxa), .rx_pxa(rx_pxa), .rx_pxa_oe(rx_pxa_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pat(input int p, input int c, input int i);
        return {8'(p), 8'(c), 8'hA5, 8'(i)};
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [31:0] mq [NP][$];
    logic [31:0] wq [NP][$];
    bit          m_en_q, m_active;
    int          m_port, m_idx;
    bit          m_dxa [NP];
    logic [31:0] e_data;
    logic        e_prty, e_soc, e_doe, e_pxa, e_poe;
    logic [NP-1:0] e_dxa;

    always @(posedge clk) begin : model
        int cp [NP];
        int a, port, idx;
        bit nul, valid, start, xfer;
        logic [7:0] ea;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                mq[p].delete(); wq[p].delete(); m_dxa[p] = 0;
            end
            m_en_q = 1; m_active = 0; m_port = 0; m_idx = 0;
            e_data = 0; e_prty = 0; e_soc = 0; e_doe = 0; e_pxa = 0; e_poe = 0; e_dxa = '0;
        end else begin
            for (int p = 0; p < NP; p++) cp[p] = mq[p].size() / CW;
            ea    = cfg_l3 ? rx_addr : {3'b0, rx_addr[4:0]};
            nul   = cfg_l3 ? (ea == 8'hFF) : (ea == 8'h1F);
            valid = !nul && (int'(ea) < NP);
            a     = int'(ea) % NP;
            start = !m_active && m_en_q && !rx_en_n && valid && (cp[a] > 0);
            xfer  = !rx_en_n && (m_active || start);
            port  = m_active ? m_port : a;
            idx   = m_active ? m_idx : 0;
            e_data = xfer ? mq[port][idx] : 32'h0;
            e_prty = cfg_even_par ? ^e_data : ~^e_data;
            e_soc  = xfer && idx == 0;
            e_doe  = cfg_l3 || xfer;
            e_pxa  = valid && m_dxa[a];
            e_poe  = cfg_l3 || !nul;
            for (int p = 0; p < NP; p++) begin
                if (cp[p] > int'(cfg_thresh)) m_dxa[p] = 1;
                else if (cp[p] == 0)          m_dxa[p] = 0;
                e_dxa[p] = m_dxa[p];
            end
            if (xfer) begin
                if (idx == CW - 1) begin
                    for (int k = 0; k < CW; k++) void'(mq[port].pop_front());
                    m_active = 0; m_idx = 0;
                end else begin
                    m_active = 1; m_port = port;
                    m_idx = (idx == 0 && !cfg_hec) ? 2 : idx + 1;
                end
            end
            m_en_q = rx_en_n;
            if (ln_we) begin
                if (!(wq[ln_port].size() == 0 && cp[ln_port] == CELLS)) begin
                    wq[ln_port].push_back(ln_data);
                    if (wq[ln_port].size() == CW) begin
                        for (int k = 0; k < CW; k++) mq[ln_port].push_back(wq[ln_port][k]);
                        wq[ln_port].delete();
                    end
                end
            end
        end
    end

    // Compare every output against the model once per clock.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(rx_data == e_data, "R8 data", rx_data, e_data);
            chk(rx_prty == e_prty, "R3 parity", 32'(rx_prty), 32'(e_prty));
            chk(rx_soc == e_soc, "R2 soc", 32'(rx_soc), 32'(e_soc));
            chk(rx_data_oe == e_doe, cfg_l3 ? "R7 data_oe" : "R6 data_oe", 32'(rx_data_oe), 32'(e_doe));
            chk(rx_dxa == e_dxa, "R4 dxa", 32'(rx_dxa), 32'(e_dxa));
            chk(rx_pxa == e_pxa, "R5 pxa", 32'(rx_pxa), 32'(e_pxa));
            chk(rx_pxa_oe == e_poe, cfg_l3 ? "R7 pxa_oe" : "R6 pxa_oe", 32'(rx_pxa_oe), 32'(e_poe));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic write_cell(input int p, input int c);
        for (int i = 0; i < CW; i++) begin
            @(negedge clk);
            ln_we = 1; ln_port = 2'(p); ln_data = pat(p, c, i);
        end
        @(negedge clk);
        ln_we = 0;
    endtask

    // Select a port, optionally pause and retarget mid-cell, hold enable past the end.
    task automatic read_cell(input logic [7:0] a, input int pause_at,
                             output int words, output int socs,
                             output logic [31:0] w0, output logic [31:0] w1);
        words = 0; socs = 0; w0 = 0; w1 = 0;
        @(negedge clk);
        rx_en_n = 1; rx_addr = a;
        @(negedge clk);
        rx_en_n = 0;
        for (int i = 0; i < 22; i++) begin
            @(negedge clk);
            if (rx_data != 0) begin
                if (words == 0) w0 = rx_data;
                if (words == 1) w1 = rx_data;
                words++;
            end
            if (rx_soc) socs++;
            if (i == 3) rx_addr = 8'h02;
            if (pause_at >= 0 && i == pause_at) rx_en_n = 1;
            if (pause_at >= 0 && i == pause_at + 2) rx_en_n = 0;
        end
        rx_en_n = 1; rx_addr = 8'hFF;
    endtask

    task automatic poll(input logic [7:0] a);
        @(negedge clk);
        rx_en_n = 1; rx_addr = a;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int w, s, tot;
        logic [31:0] f0, f1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rx_data == 0 && !rx_soc && !rx_prty && !rx_data_oe, "R11 reset data", rx_data, 0);
        chk(rx_dxa == 0 && !rx_pxa && !rx_pxa_oe, "R11 reset flags", 32'(rx_dxa), 0);
        rst_n = 1;
        chk_on = 1;

        // Shared-bus mode, header word on, odd parity, threshold 1
        write_cell(0, 0); write_cell(0, 1); write_cell(2, 0);
        repeat (2) @(negedge clk);
        chk(rx_dxa[0] == 1, "R4 two cells above thr", 32'(rx_dxa), 32'h1);
        chk(rx_dxa[2] == 0, "R4 one cell not above thr", 32'(rx_dxa), 32'h1);
        poll(8'hE0);
        chk(rx_pxa == 1 && rx_pxa_oe == 1, "R6 low five bits decoded", 32'(rx_pxa), 1);
        poll(8'hFF);
        chk(rx_pxa == 0 && rx_pxa_oe == 0, "R6 null undriven", 32'(rx_pxa_oe), 0);
        read_cell(8'h00, 6, w, s, f0, f1);
        chk(w == 13, "R8 header on word count", w, 13);
        chk(s == 1, "R2 one soc per cell", s, 1);
        chk(f0 == pat(0, 0, 0), "R1 first word at select", f0, pat(0, 0, 0));
        chk(f1 == pat(0, 0, 1), "R9 word after pause", f1, pat(0, 0, 1));
        repeat (2) @(negedge clk);
        chk(rx_dxa[0] == 1, "R4 hysteresis holds", 32'(rx_dxa), 32'h1);
        poll(8'h00);
        chk(rx_pxa == 1, "R5 poll port0", 32'(rx_pxa), 1);
        read_cell(8'h01, -1, w, s, f0, f1);
        chk(w == 0, "R1 empty port no transfer", w, 0);
        read_cell(8'h00, -1, w, s, f0, f1);
        chk(w == 13 && f0 == pat(0, 1, 0), "R10 one cell then release", w, 13);
        repeat (2) @(negedge clk);
        chk(rx_dxa[0] == 0, "R4 clears at empty", 32'(rx_dxa), 0);

        // Header word off, even parity
        cfg_hec = 0; cfg_even_par = 1;
        write_cell(2, 1);
        repeat (2) @(negedge clk);
        chk(rx_dxa[2] == 1, "R4 port2 above thr", 32'(rx_dxa), 32'h4);
        read_cell(8'h02, -1, w, s, f0, f1);
        chk(w == 12, "R8 header off word count", w, 12);
        chk(f1 == pat(2, 0, 2), "R8 stored word 1 skipped", f1, pat(2, 0, 2));

        // Point-to-point mode
        cfg_l3 = 1;
        repeat (2) @(negedge clk);
        chk(rx_data_oe && rx_pxa_oe, "R7 always driven", 32'({rx_data_oe, rx_pxa_oe}), 3);
        poll(8'h1F);
        chk(rx_pxa_oe == 1 && rx_pxa == 0, "R7 1F not null", 32'(rx_pxa_oe), 1);
        poll(8'hFF);
        chk(rx_pxa == 0, "R5 null reads low", 32'(rx_pxa), 0);
        read_cell(8'h02, 4, w, s, f0, f1);
        chk(w == 12 && s == 1, "R9 pause in point-to-point", w, 12);
        repeat (2) @(negedge clk);
        chk(rx_dxa[2] == 0, "R4 port2 empty", 32'(rx_dxa), 0);

        // Overflow: five cells into a four-cell store
        cfg_thresh = 3'd3; cfg_hec = 1;
        for (int c = 0; c < 5; c++) write_cell(3, c);
        repeat (2) @(negedge clk);
        chk(rx_dxa[3] == 1, "R12 full store flag", 32'(rx_dxa), 32'h8);
        tot = 0;
        for (int c = 0; c < 5; c++) begin
            read_cell(8'h03, -1, w, s, f0, f1);
            tot += s;
        end
        chk(tot == CELLS, "R12 fifth cell dropped", tot, CELLS);
        repeat (2) @(negedge clk);
        chk(rx_dxa == 0, "R12 all empty", 32'(rx_dxa), 0);

        chk_on = 0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule